// File: doc/BRIEF.md
# Two-Bank SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a synchronous DRAM pin interface. On every rising clock edge it samples the chip-select, row-strobe, column-strobe, write-enable, clock-enable, bank-select and address pins. It sorts the cycle into one command class and reports that class as a registered code. It also keeps an open/closed state for each of the two banks, holds the row address each bank was opened with, and holds the last column address that was addressed in each bank.

Clock enable decides which edges are honoured. When it is sampled low, the edges that follow are ignored and all tracked state holds still. If both banks are closed at the moment of entry, the block also reports power-down. Recovery is synchronous: once clock enable is sampled high again, the next edge is decoded normally. A sticky flag records commands that break the bank protocol.

The pins carry no handshake. A controller drives one command per cycle, and the device side has no way to stall it, so there is no back-pressure. Every result is registered and appears one edge after the inputs are sampled.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `cs_n` high on an honoured edge, `cmd_code` becomes 1 (deselect) after that edge, and bank state, rows, columns and `cmd_bank` are unchanged.
- R2: With `cs_n` low on an honoured edge, `{ras_n,cas_n,we_n}` selects the code shown on `cmd_code` after the edge: 111→2 no-op, 011→3 activate, 101→4 read, 100→5 write, 010→6 precharge, 001→7 refresh, 000→8 mode set, 110→9 other. `cmd_code` is 0 after an edge that is not honoured.
- R3: An activate to a closed bank opens the bank selected by `ba` (bank b on bit b of `bank_active`) and stores `addr` in `rows[b*ROW_W +: ROW_W]`.
- R4: A read or write to an open bank stores `addr[COL_W-1:0]` in `cols[b*COL_W +: COL_W]`. COL_W is 8, 9 or 10 for a data width `DQ_W` of 16, 8 or 4.
- R5: `cmd_bank` takes `ba` on honoured activate, read, write, precharge and mode-set commands, and holds its value on all other cycles.
- R6: A precharge with `addr[ROW_W-1]` high closes both banks. With that bit low, it closes only the bank that `ba` selects.
- R7: If `cke` is sampled low on edge t, every edge from t+1 onward is ignored until `cke` is sampled high again. `suspended` is high while edges are ignored, and bank state, rows, columns and `cmd_bank` stay frozen.
- R8: `power_down` is set after an honoured edge that samples `cke` low when both banks are closed after that edge. It stays set while `cke` stays low.
- R9: An ignored edge that samples `cke` high clears `power_down` and `suspended`, and the next edge is decoded.
- R10: An activate to an open bank, or a read or write to a closed bank, sets `proto_err`, which stays set until reset. Such a command leaves that bank's row and column unchanged.
- R11: During and after reset, all outputs are 0: no bank open, no flags, and `cmd_code` equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank select |
| addr | input | ROW_W | Multiplexed address; top bit doubles as the precharge-all flag |
| cmd_code | output | 4 | Decoded command of the last edge |
| cmd_bank | output | 1 | Last captured bank select |
| bank_active | output | 2 | Open state per bank |
| rows | output | 2*ROW_W | Row address held per bank |
| cols | output | 2*COL_W | Column address held per bank |
| suspended | output | 1 | Next edge will be ignored |
| power_down | output | 1 | Suspended with both banks closed |
| proto_err | output | 1 | Sticky protocol violation |

## Verification
The bench cycles through all sixteen combinations of the four strobe pins, crossed with both bank selects. The address values are computed so that the precharge-all bit and the column bits vary. Clock enable is pulled low at regular intervals throughout this sweep. As a result, every command is seen by open banks and by closed banks. This separates a legal open from a duplicate activate, a column capture from a read to a closed bank, and single-bank precharge from precharge-all. The clock-enable pulses tell an honoured edge apart from a frozen one. They also tell plain suspend, which starts with a bank open, apart from power-down, which starts with both banks closed. Directed sequences then test one-edge entry to power-down, synchronous exit, and selective precharge against expected values.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam int NUM_BANKS = 2;

  typedef enum logic [3:0] {
    CMD_NONE  = 4'd0,
    CMD_DESEL = 4'd1,
    CMD_NOP   = 4'd2,
    CMD_ACT   = 4'd3,
    CMD_RD    = 4'd4,
    CMD_WR    = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_REF   = 4'd7,
    CMD_MRS   = 4'd8,
    CMD_OTHER = 4'd9
  } cmd_e;

  // column width from data organization
  function automatic int col_width(input int dq_w);
    case (dq_w)
      4:       return 10;
      8:       return 9;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/sdr_cke_ctrl.sv
module sdr_cke_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic idle_next,
  output logic accept,
  output logic suspended,
  output logic power_down
);
  logic cke_prev;
  logic pd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_prev <= 1'b1;
      pd_q     <= 1'b0;
    end else begin
      cke_prev <= cke;
      if (cke_prev) pd_q <= !cke && idle_next;
      else          pd_q <= pd_q && !cke;
    end
  end

  assign accept     = cke_prev;
  assign suspended  = !cke_prev;
  assign power_down = pd_q;
endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
  import sdr_pkg::*;
#(
  parameter int BANK_ID = 0,
  parameter int ROW_W   = 11,
  parameter int COL_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  cmd_e             cmd,
  input  logic             ba,
  input  logic [ROW_W-1:0] addr,
  output logic             active,
  output logic             active_next,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             err_hit
);
  localparam logic MY_BA  = 1'(BANK_ID);
  localparam int   AP_BIT = ROW_W - 1;

  logic sel;
  logic row_en;
  logic col_en;

  assign sel = (ba == MY_BA);

  always_comb begin
    active_next = active;
    row_en      = 1'b0;
    col_en      = 1'b0;
    err_hit     = 1'b0;
    if (accept) begin
      case (cmd)
        CMD_ACT: if (sel) begin
          if (active) err_hit = 1'b1;
          else begin
            active_next = 1'b1;
            row_en      = 1'b1;
          end
        end
        CMD_RD, CMD_WR: if (sel) begin
          if (active) col_en  = 1'b1;
          else        err_hit = 1'b1;
        end
        CMD_PRE: if (sel || addr[AP_BIT]) active_next = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      row    <= '0;
      col    <= '0;
    end else begin
      active <= active_next;
      if (row_en) row <= addr;
      if (col_en) col <= addr[COL_W-1:0];
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdr_pkg::*;
#(
  parameter int DQ_W  = 16,
  parameter int ROW_W = 11,
  parameter int COL_W = sdr_pkg::col_width(DQ_W)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic                       ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [3:0]                 cmd_code,
  output logic                       cmd_bank,
  output logic [NUM_BANKS-1:0]       bank_active,
  output logic [NUM_BANKS*ROW_W-1:0] rows,
  output logic [NUM_BANKS*COL_W-1:0] cols,
  output logic                       suspended,
  output logic                       power_down,
  output logic                       proto_err
);
  cmd_e                 cmd_dec;
  cmd_e                 cmd_q;
  logic                 accept;
  logic [NUM_BANKS-1:0] act_next;
  logic [NUM_BANKS-1:0] err_hit;
  logic                 bank_q;
  logic                 err_q;
  logic                 takes_bank;

  sdr_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd_dec)
  );

  sdr_cke_ctrl u_cke (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .idle_next  (~|act_next),
    .accept     (accept),
    .suspended  (suspended),
    .power_down (power_down)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdr_bank_track #(
      .BANK_ID (g),
      .ROW_W   (ROW_W),
      .COL_W   (COL_W)
    ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .cmd         (cmd_dec),
      .ba          (ba),
      .addr        (addr),
      .active      (bank_active[g]),
      .active_next (act_next[g]),
      .row         (rows[g*ROW_W +: ROW_W]),
      .col         (cols[g*COL_W +: COL_W]),
      .err_hit     (err_hit[g])
    );
  end

  always_comb begin
    case (cmd_dec)
      CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_MRS: takes_bank = 1'b1;
      default:                                   takes_bank = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NONE;
      bank_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cmd_q <= accept ? cmd_dec : CMD_NONE;
      if (accept && takes_bank) bank_q <= ba;
      err_q <= err_q | (|err_hit);
    end
  end

  assign cmd_code  = cmd_q;
  assign cmd_bank  = bank_q;
  assign proto_err = err_q;
endmodule

// File: rtl/sdr_tracker_chk.sv
module sdr_tracker_chk #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             ba,
  input logic             addr_ap,
  input logic [3:0]       cmd_code,
  input logic [1:0]       bank_active,
  input logic [2*ROW_W-1:0] rows,
  input logic             suspended,
  input logic             power_down,
  input logic             proto_err
);
  // R1
  desel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspended && cs_n) |=> (cmd_code == 4'd1));

  // R3
  act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspended && !cs_n && !ras_n && cas_n && we_n && !ba && !bank_active[0])
      |=> bank_active[0]);

  // R6
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspended && !cs_n && !ras_n && cas_n && !we_n && addr_ap)
      |=> (bank_active == 2'b00));

  // R7
  susp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |=> ($stable(bank_active) && $stable(rows) && cmd_code == 4'd0));

  // R8
  pd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> (bank_active == 2'b00 && suspended));

  // R9
  pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (power_down && cke) |=> (!power_down && !suspended));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

bind sdram_cmd_tracker sdr_tracker_chk #(.ROW_W(ROW_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cke         (cke),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .ba          (ba),
  .addr_ap     (addr[ROW_W-1]),
  .cmd_code    (cmd_code),
  .bank_active (bank_active),
  .rows        (rows),
  .suspended   (suspended),
  .power_down  (power_down),
  .proto_err   (proto_err)
);

// File: tb/sim_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sim_sdram_cmd_tracker;
  localparam int ROW_W = 11;
  localparam int COL_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, ba = 1'b0;
  logic [ROW_W-1:0]   addr = '0;
  logic [3:0]         cmd_code;
  logic               cmd_bank;
  logic [1:0]         bank_active;
  logic [2*ROW_W-1:0] rows;
  logic [2*COL_W-1:0] cols;
  logic               suspended, power_down, proto_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  logic [ROW_W-1:0] m_row [2];
  logic [COL_W-1:0] m_col [2];
  logic [1:0]       m_act;
  logic             m_err, m_last, m_pd, m_susp;
  logic [3:0]       m_code;

  always #10 clk = ~clk;

  sdram_cmd_tracker #(.DQ_W(16), .ROW_W(ROW_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .bank_active(bank_active),
    .rows(rows), .cols(cols), .suspended(suspended),
    .power_down(power_down), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] code_of(input bit c, input bit r, input bit ca, input bit w);
    if (c) return 4'd1;
    case ({r, ca, w})
      3'b111: return 4'd2;
      3'b011: return 4'd3;
      3'b101: return 4'd4;
      3'b100: return 4'd5;
      3'b010: return 4'd6;
      3'b001: return 4'd7;
      3'b000: return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  task automatic model_clear();
    m_row[0] = '0; m_row[1] = '0; m_col[0] = '0; m_col[1] = '0;
    m_act = 2'b00; m_err = 0; m_last = 0; m_pd = 0; m_susp = 0; m_code = 4'd0;
  endtask

  task automatic compare_all();
    chk(cmd_code == m_code, cs_n ? "R1 code" : "R2 code", cmd_code, m_code);
    chk(bank_active == m_act, "R3 bank_active", bank_active, m_act);
    chk(rows == {m_row[1], m_row[0]}, "R3 rows", rows, {m_row[1], m_row[0]});
    chk(cols == {m_col[1], m_col[0]}, "R4 cols", cols, {m_col[1], m_col[0]});
    chk(cmd_bank == m_last, "R5 cmd_bank", cmd_bank, m_last);
    chk(suspended == m_susp, "R7 suspended", suspended, m_susp);
    chk(power_down == m_pd, "R8 power_down", power_down, m_pd);
    chk(proto_err == m_err, "R10 proto_err", proto_err, m_err);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    // R11 reset state
    chk({cmd_code, cmd_bank, bank_active, suspended, power_down, proto_err} == '0,
        "R11 reset flags", {cmd_code, cmd_bank, bank_active, suspended, power_down, proto_err}, 0);
    chk(rows == '0 && cols == '0, "R11 reset addr", {rows, cols}, 0);
  endtask

  // called at a negedge; applies one cycle and checks after the edge
  task automatic step(input bit k, input bit c, input bit r, input bit ca, input bit w,
                      input bit b, input logic [ROW_W-1:0] a);
    logic [3:0] cd;
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    @(posedge clk);
    if (!m_susp) begin
      cd = code_of(c, r, ca, w);
      m_code = cd;
      case (cd)
        4'd3: if (m_act[b]) m_err = 1; else begin m_act[b] = 1; m_row[b] = a; end
        4'd4, 4'd5: if (m_act[b]) m_col[b] = a[COL_W-1:0]; else m_err = 1;
        4'd6: if (a[ROW_W-1]) m_act = 2'b00; else m_act[b] = 0;
        default: ;
      endcase
      if (cd == 4'd3 || cd == 4'd4 || cd == 4'd5 || cd == 4'd6 || cd == 4'd8) m_last = b;
      m_pd = !k && (m_act == 2'b00);
    end else begin
      m_code = 4'd0;
      m_pd = m_pd && !k;
    end
    m_susp = !k;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // sweep: all strobe combinations x bank, varied address and cke
    for (int i = 0; i < 640; i++) begin
      logic [3:0] cb;
      logic [ROW_W-1:0] a;
      cb = 4'((i * 5 + i / 16) & 15);
      a  = ROW_W'((i * 181 + 37) & 2047);
      if ((i % 3) != 0) a[ROW_W-1] = 1'b0;
      step(((i % 13) != 12) && ((i % 29) != 28), cb[3], cb[2], cb[1], cb[0], i[4] ^ i[0], a);
    end

    // R6 selective precharge
    do_reset();
    step(1, 0, 0, 1, 1, 0, 11'h123);
    step(1, 0, 0, 1, 1, 1, 11'h2a5);
    step(1, 0, 0, 1, 0, 0, 11'h000);
    chk(bank_active == 2'b10, "R6 single precharge", bank_active, 2'b10);
    step(1, 0, 0, 1, 0, 0, 11'h400);
    chk(bank_active == 2'b00, "R6 precharge all", bank_active, 2'b00);

    // R1 deselect leaves state alone
    step(1, 0, 0, 1, 1, 1, 11'h3c3);
    step(1, 1, 0, 1, 0, 1, 11'h400);
    chk(bank_active == 2'b10 && cmd_code == 4'd1, "R1 deselect ignored",
        {cmd_code, bank_active}, {4'd1, 2'b10});

    // R7 suspend with an open bank: no power-down, frozen state
    step(0, 0, 1, 0, 1, 1, 11'h055);
    chk(suspended && !power_down, "R7 suspend entry", {suspended, power_down}, 2'b10);
    step(0, 0, 0, 1, 0, 0, 11'h400);
    chk(bank_active == 2'b10 && cmd_code == 4'd0, "R7 frozen", {cmd_code, bank_active}, {4'd0, 2'b10});
    step(1, 1, 1, 1, 1, 0, 11'h000);
    step(1, 0, 0, 1, 0, 0, 11'h400);
    chk(bank_active == 2'b00, "R7 resumed precharge", bank_active, 2'b00);

    // R8/R9 power-down entry and synchronous exit
    step(0, 0, 1, 1, 1, 0, 11'h000);
    chk(power_down == 1'b1, "R8 power-down entry", power_down, 1);
    step(0, 0, 0, 1, 1, 0, 11'h111);
    chk(bank_active == 2'b00 && power_down, "R8 held in power-down", {bank_active, power_down}, 3'b001);
    step(1, 0, 0, 1, 1, 0, 11'h222);
    chk(!power_down && !suspended && bank_active == 2'b00, "R9 exit edge",
        {power_down, suspended, bank_active}, 0);
    step(1, 0, 0, 1, 1, 0, 11'h333);
    chk(bank_active == 2'b01 && rows[ROW_W-1:0] == 11'h333, "R9 accepted after exit",
        {bank_active, rows[ROW_W-1:0]}, {2'b01, 11'h333});

    // R10 duplicate activate keeps row, flag sticks
    step(1, 0, 0, 1, 1, 0, 11'h0ff);
    chk(proto_err && rows[ROW_W-1:0] == 11'h333, "R10 duplicate activate",
        {proto_err, rows[ROW_W-1:0]}, {1'b1, 11'h333});
    step(1, 0, 1, 1, 1, 0, 11'h000);
    chk(proto_err == 1'b1, "R10 sticky", proto_err, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule